// File: doc/BRIEF.md
# Condition-code branch resolver

This block settles the control-flow outcome of a relative branch. It holds a four-bit condition-code register with negative, zero, overflow and carry flags. A small flag generator updates that register from an add, a subtract/compare, a move or a test against zero. When a branch is presented, the block decodes its 8-bit opcode and tests the held flags. It then returns whether the branch is taken and which program counter comes next.

The displacement is signed. It is added to the address of the first byte of the instruction that follows the branch, not to the branch's own address. Two unconditional forms exist: a short one with an 8-bit displacement and a long one with a 16-bit displacement. Every conditional form uses an 8-bit displacement. Signed relational tests read the N flag. Unsigned relational tests read the C flag, which holds the borrow. The carry-set and carry-clear tests share their codes with the unsigned less-than and greater-or-equal tests. Branches never alter the flags.

A flag update and a branch may arrive in the same cycle. In that case the branch is judged on the flags held before the update. Results are registered and appear one clock after the request.

Top module: `cc_branch_resolver`

## Requirements
- R1: While rst_n is low at a clock edge, res_valid, res_taken and res_illegal become 0, res_npc becomes 0 and cc_flags becomes 0.
- R2: cc_flags is ordered {N,Z,V,C} (bit 3 = N, bit 0 = C). It takes the generator's flags one edge after a cycle with alu_valid=1. Otherwise it holds, including across any number of branches.
- R3: With alu_op=0 (add), N is the result's top bit and Z is set when the 32-bit result is zero. V is set on signed overflow and C on carry out. For example, 40000000h+40000000h gives flags 1010b.
- R4: With alu_op=1 (subtract/compare, a minus b), N and Z follow the difference. C is set when a<b unsigned (borrow), and V is set on signed overflow of a-b.
- R5: With alu_op=2 (move a), N and Z follow a, V is cleared and C is kept. With alu_op=3 (test a against zero), N and Z follow a and both V and C are cleared.
- R6: A branch sampled with br_valid=1 produces res_valid=1 one edge later. It is judged on the flags held at the sampling edge, even if alu_valid is also 1 in that cycle. res_valid is 0 after a cycle without br_valid.
- R7: A taken target is br_next_pc plus the sign-extended displacement, modulo 2^32. Byte forms use br_disp[7:0] and ignore br_disp[15:8].
- R8: Opcode 11h (short) and opcode 31h (long, all 16 bits of br_disp) are always taken.
- R9: Opcode 13h is taken when Z=1 and opcode 12h when Z=0.
- R10: Signed tests: 14h is taken when N=0 and Z=0, 15h when N=1 or Z=1, 18h when N=0, and 19h when N=1.
- R11: Unsigned and carry tests: 1Ah is taken when C=0 and Z=0, 1Bh when C=1 or Z=1, 1Eh when C=0, and 1Fh when C=1.
- R12: Opcode 1Dh is taken when V=1 and 1Ch when V=0.
- R13: Any other opcode gives res_illegal=1 and res_taken=0.
- R14: Whenever res_taken=0, res_npc equals the br_next_pc that was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alu_valid | input | 1 | Update the condition codes this cycle |
| alu_op | input | 2 | 0 add, 1 subtract/compare, 2 move, 3 test |
| alu_a | input | 32 | First operand |
| alu_b | input | 32 | Second operand |
| br_valid | input | 1 | Resolve a branch this cycle |
| br_opcode | input | 8 | Branch opcode |
| br_disp | input | 16 | Displacement (low byte for byte forms) |
| br_next_pc | input | 32 | Address of the next sequential instruction |
| cc_flags | output | 4 | Held condition codes {N,Z,V,C} |
| res_valid | output | 1 | Branch result present |
| res_taken | output | 1 | Branch taken |
| res_illegal | output | 1 | Opcode not recognised |
| res_npc | output | 32 | Next program counter |

## Verification
The assertions check the following on every cycle:
- the flags hold whenever no update is requested;
- a result appears exactly one cycle after each request;
- an unconditional opcode is always taken;
- an unrecognised opcode is never taken;
- an untaken branch returns the sequential address.

Only the bench's scenarios can show the rest:
- whether each conditional code reads the right flags;
- whether the flag generator gets overflow and borrow right, including the case where N disagrees with the true sign;
- whether displacement sign extension and 32-bit wraparound are correct;
- that a same-cycle flag update does not leak into the branch decision.

// File: rtl/ccb_pkg.sv
// Package: shared types and opcode constants for the condition-code
// branch resolver. Assumes 8-bit opcodes and a four-flag register.
package ccb_pkg;

    // Flag generator operations.
    typedef enum logic [1:0] {
        ALU_ADD  = 2'd0,
        ALU_SUB  = 2'd1,
        ALU_MOVE = 2'd2,
        ALU_TEST = 2'd3
    } alu_op_e;

    // Branch decode classes.
    typedef enum logic [1:0] {
        KIND_ILLEGAL = 2'd0,
        KIND_COND    = 2'd1,
        KIND_SHORT   = 2'd2,
        KIND_LONG    = 2'd3
    } br_kind_e;

    // Condition codes, packed in the order {N,Z,V,C}.
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

    // Opcode constants.
    localparam logic [7:0] OPC_BR_SHORT = 8'h11;
    localparam logic [7:0] OPC_BR_LONG  = 8'h31;
    localparam logic [7:0] OPC_NE       = 8'h12;
    localparam logic [7:0] OPC_EQ       = 8'h13;
    localparam logic [7:0] OPC_GT       = 8'h14;
    localparam logic [7:0] OPC_LE       = 8'h15;
    localparam logic [7:0] OPC_GE       = 8'h18;
    localparam logic [7:0] OPC_LT       = 8'h19;
    localparam logic [7:0] OPC_GTU      = 8'h1A;
    localparam logic [7:0] OPC_LEU      = 8'h1B;
    localparam logic [7:0] OPC_VC       = 8'h1C;
    localparam logic [7:0] OPC_VS       = 8'h1D;
    localparam logic [7:0] OPC_GEU_CC   = 8'h1E;
    localparam logic [7:0] OPC_LTU_CS   = 8'h1F;

endpackage

// File: rtl/ccb_flag_gen.sv
// Module: ccb_flag_gen
// Computes the next condition codes from an add, subtract/compare, move or
// test-against-zero. The flags describe the wrapped DATA_W-bit result, so N
// may disagree with the true sign when V is set. Purely combinational.
// Assumes DATA_W >= 2.
module ccb_flag_gen
    import ccb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  cc_t               cc_old,
    output cc_t               cc_new
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0]   sum_ext;
    logic [DATA_W:0]   dif_ext;
    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] dif_w;
    logic              add_ovf;
    logic              sub_ovf;

    // Wide add and subtract; the extra bit is the carry or the borrow.
    always_comb begin
        sum_ext = {1'b0, a} + {1'b0, b};
        dif_ext = {1'b0, a} - {1'b0, b};
        sum_w   = sum_ext[MSB:0];
        dif_w   = dif_ext[MSB:0];
    end

    // Signed overflow: operand signs against the sign of the stored result.
    always_comb begin
        add_ovf = (a[MSB] == b[MSB]) && (sum_w[MSB] != a[MSB]);
        sub_ovf = (a[MSB] != b[MSB]) && (dif_w[MSB] != a[MSB]);
    end

    // Select the flags for the requested operation.
    always_comb begin
        unique case (op)
            ALU_ADD: begin
                cc_new.n = sum_w[MSB];
                cc_new.z = (sum_w == '0);
                cc_new.v = add_ovf;
                cc_new.c = sum_ext[DATA_W];
            end
            ALU_SUB: begin
                cc_new.n = dif_w[MSB];
                cc_new.z = (dif_w == '0);
                cc_new.v = sub_ovf;
                cc_new.c = dif_ext[DATA_W];
            end
            ALU_MOVE: begin
                cc_new.n = a[MSB];
                cc_new.z = (a == '0);
                cc_new.v = 1'b0;
                cc_new.c = cc_old.c;
            end
            default: begin
                cc_new.n = a[MSB];
                cc_new.z = (a == '0);
                cc_new.v = 1'b0;
                cc_new.c = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ccb_cond_eval.sv
// Module: ccb_cond_eval
// Decodes a branch opcode into its class and evaluates its test against the
// held condition codes. Signed order is read from N, unsigned order from
// the borrow in C. Combinational.
module ccb_cond_eval
    import ccb_pkg::*;
(
    input  logic [7:0] opcode,
    input  cc_t        cc,
    output br_kind_e   kind,
    output logic       take
);
    logic cond_hit;

    // Opcode class lookup.
    always_comb begin
        unique case (opcode)
            OPC_BR_SHORT: kind = KIND_SHORT;
            OPC_BR_LONG:  kind = KIND_LONG;
            OPC_NE, OPC_EQ, OPC_GT, OPC_LE, OPC_GE, OPC_LT,
            OPC_GTU, OPC_LEU, OPC_VC, OPC_VS,
            OPC_GEU_CC, OPC_LTU_CS: kind = KIND_COND;
            default:      kind = KIND_ILLEGAL;
        endcase
    end

    // Condition test of each conditional code.
    always_comb begin
        unique case (opcode)
            OPC_EQ:     cond_hit = cc.z;
            OPC_NE:     cond_hit = !cc.z;
            OPC_GT:     cond_hit = !(cc.n || cc.z);
            OPC_LE:     cond_hit = cc.n || cc.z;
            OPC_GE:     cond_hit = !cc.n;
            OPC_LT:     cond_hit = cc.n;
            OPC_GTU:    cond_hit = !(cc.c || cc.z);
            OPC_LEU:    cond_hit = cc.c || cc.z;
            OPC_GEU_CC: cond_hit = !cc.c;
            OPC_LTU_CS: cond_hit = cc.c;
            OPC_VS:     cond_hit = cc.v;
            OPC_VC:     cond_hit = !cc.v;
            default:    cond_hit = 1'b0;
        endcase
    end

    // Final take decision per class.
    always_comb begin
        unique case (kind)
            KIND_SHORT, KIND_LONG: take = 1'b1;
            KIND_COND:             take = cond_hit;
            default:               take = 1'b0;
        endcase
    end

endmodule

// File: rtl/ccb_target_add.sv
// Module: ccb_target_add
// Sign-extends a byte or word displacement and adds it to the address of
// the next sequential instruction, wrapping at ADDR_W bits. Assumes
// ADDR_W > DISP_W >= 8. Combinational.
module ccb_target_add #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input  logic [ADDR_W-1:0] seq_pc,
    input  logic [DISP_W-1:0] disp,
    input  logic              use_long,
    output logic [ADDR_W-1:0] target
);
    localparam int BYTE_W = 8;

    logic [ADDR_W-1:0] ext_byte;
    logic [ADDR_W-1:0] ext_long;
    logic [ADDR_W-1:0] offset;

    // Sign extension of both displacement widths.
    always_comb begin
        ext_byte = {{(ADDR_W-BYTE_W){disp[BYTE_W-1]}}, disp[BYTE_W-1:0]};
        ext_long = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    end

    // Offset pick and modular add.
    always_comb begin
        offset = use_long ? ext_long : ext_byte;
        target = seq_pc + offset;
    end

endmodule

// File: rtl/cc_branch_resolver.sv
// Module: cc_branch_resolver (top)
// Holds the condition-code register, updates it from the flag generator and
// resolves one relative branch per cycle against the held flags. Results
// are registered: they appear one clock after the request. A same-cycle
// flag update is not seen by the branch. Synchronous active-low reset.
module cc_branch_resolver
    import ccb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_valid,
    input  logic [1:0]        alu_op,
    input  logic [DATA_W-1:0] alu_a,
    input  logic [DATA_W-1:0] alu_b,
    input  logic              br_valid,
    input  logic [7:0]        br_opcode,
    input  logic [DISP_W-1:0] br_disp,
    input  logic [ADDR_W-1:0] br_next_pc,
    output logic [3:0]        cc_flags,
    output logic              res_valid,
    output logic              res_taken,
    output logic              res_illegal,
    output logic [ADDR_W-1:0] res_npc
);
    cc_t               cc_q;
    cc_t               cc_d;
    br_kind_e          kind;
    logic              take;
    logic [ADDR_W-1:0] target;

    ccb_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .op     (alu_op_e'(alu_op)),
        .a      (alu_a),
        .b      (alu_b),
        .cc_old (cc_q),
        .cc_new (cc_d)
    );

    ccb_cond_eval u_cond (
        .opcode (br_opcode),
        .cc     (cc_q),
        .kind   (kind),
        .take   (take)
    );

    ccb_target_add #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
        .seq_pc   (br_next_pc),
        .disp     (br_disp),
        .use_long (kind == KIND_LONG),
        .target   (target)
    );

    // Condition-code register: loads only on a flag update request.
    always_ff @(posedge clk) begin
        if (!rst_n)         cc_q <= '0;
        else if (alu_valid) cc_q <= cc_d;
    end

    // Branch result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_taken   <= 1'b0;
            res_illegal <= 1'b0;
            res_npc     <= '0;
        end else begin
            res_valid <= br_valid;
            if (br_valid) begin
                res_taken   <= take;
                res_illegal <= (kind == KIND_ILLEGAL);
                res_npc     <= take ? target : br_next_pc;
            end
        end
    end

    assign cc_flags = cc_q;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !res_taken && !res_illegal && cc_flags == 4'd0)); // R1
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !alu_valid |=> $stable(cc_flags)); // R2
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> res_valid); // R6
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> !res_valid); // R6
    AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && (br_opcode == OPC_BR_SHORT || br_opcode == OPC_BR_LONG))
        |=> (res_taken && !res_illegal)); // R8
    AST_ILLEGAL_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_illegal) |-> !res_taken); // R13
    AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken) |-> (res_npc == $past(br_next_pc))); // R14

endmodule

// File: tb/tb_cc_branch_resolver.sv
// Bench for cc_branch_resolver: a vector table walked by one loop, then
// directed tests for reset, same-cycle update and result timing.
module tb_cc_branch_resolver;
    import ccb_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alu_valid = 1'b0;
    logic [1:0]  alu_op = 2'd0;
    logic [31:0] alu_a = '0;
    logic [31:0] alu_b = '0;
    logic        br_valid = 1'b0;
    logic [7:0]  br_opcode = '0;
    logic [15:0] br_disp = '0;
    logic [31:0] br_next_pc = '0;
    logic [3:0]  cc_flags;
    logic        res_valid;
    logic        res_taken;
    logic        res_illegal;
    logic [31:0] res_npc;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cc_branch_resolver dut (
        .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_op(alu_op),
        .alu_a(alu_a), .alu_b(alu_b), .br_valid(br_valid),
        .br_opcode(br_opcode), .br_disp(br_disp), .br_next_pc(br_next_pc),
        .cc_flags(cc_flags), .res_valid(res_valid), .res_taken(res_taken),
        .res_illegal(res_illegal), .res_npc(res_npc)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [7:0]  opc;
        logic [15:0] disp;
        logic [31:0] npc;
        logic [3:0]  xflags;
        logic        xtaken;
        logic        xillegal;
        logic [31:0] xnpc;
    } vec_t;

    localparam int NV = 16;
    // Flags are {N,Z,V,C}. Vectors run in order; MOVE keeps the previous C.
    localparam vec_t VECS [NV] = '{
        '{2'd1, 32'h5,        32'h5,        8'h13, 16'h0008, 32'h1000,     4'b0100, 1'b1, 1'b0, 32'h1008},     // R9 R4
        '{2'd1, 32'h5,        32'h3,        8'h12, 16'h00F8, 32'h1000,     4'b0000, 1'b1, 1'b0, 32'h0FF8},     // R9 R7
        '{2'd1, 32'h3,        32'h5,        8'h14, 16'h0010, 32'h2000,     4'b1001, 1'b0, 1'b0, 32'h2000},     // R10 R4
        '{2'd1, 32'h3,        32'h5,        8'h19, 16'h0010, 32'h2000,     4'b1001, 1'b1, 1'b0, 32'h2010},     // R10
        '{2'd1, 32'h80000000, 32'h40000000, 8'h1A, 16'h007F, 32'h3000,     4'b0010, 1'b1, 1'b0, 32'h307F},     // R11 R4
        '{2'd1, 32'h80000000, 32'h40000000, 8'h18, 16'h0080, 32'h3000,     4'b0010, 1'b1, 1'b0, 32'h2F80},     // R10 R7
        '{2'd1, 32'h80000000, 32'h40000000, 8'h1D, 16'h0002, 32'h4000,     4'b0010, 1'b1, 1'b0, 32'h4002},     // R12
        '{2'd0, 32'h40000000, 32'h40000000, 8'h1C, 16'h0002, 32'h5000,     4'b1010, 1'b0, 1'b0, 32'h5000},     // R3 R12
        '{2'd0, 32'hFFFFFFFF, 32'h1,        8'h1B, 16'h0004, 32'h6000,     4'b0101, 1'b1, 1'b0, 32'h6004},     // R3 R11
        '{2'd0, 32'hFFFFFFFF, 32'h1,        8'h1F, 16'h00FC, 32'h6000,     4'b0101, 1'b1, 1'b0, 32'h5FFC},     // R11
        '{2'd0, 32'hFFFFFFFF, 32'h1,        8'h15, 16'h0001, 32'h7000,     4'b0101, 1'b1, 1'b0, 32'h7001},     // R10
        '{2'd2, 32'h80000000, 32'h0,        8'h1E, 16'h0004, 32'h8000,     4'b1001, 1'b0, 1'b0, 32'h8000},     // R5 R11
        '{2'd3, 32'h0,        32'h0,        8'h31, 16'h8000, 32'h00010000, 4'b0100, 1'b1, 1'b0, 32'h00008000}, // R5 R8
        '{2'd0, 32'h1,        32'h2,        8'h11, 16'h1234, 32'hFFFFFFF0, 4'b0000, 1'b1, 1'b0, 32'h00000024}, // R8 R7
        '{2'd1, 32'h1,        32'h2,        8'h1A, 16'h0010, 32'h9000,     4'b1001, 1'b0, 1'b0, 32'h9000},     // R11 R14
        '{2'd0, 32'h7FFFFFFF, 32'h1,        8'h00, 16'h0010, 32'hA000,     4'b1010, 1'b0, 1'b1, 32'hA000}      // R13 R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk("R1 res_valid", {31'd0, res_valid}, 32'd0);
        chk("R1 res_taken", {31'd0, res_taken}, 32'd0);
        chk("R1 res_illegal", {31'd0, res_illegal}, 32'd0);
        chk("R1 res_npc", res_npc, 32'd0);
        chk("R1 cc_flags", {28'd0, cc_flags}, 32'd0);
        rst_n = 1'b1;

        // Table walk: flag update, then branch, then check.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            alu_valid = 1'b1; alu_op = VECS[i].op; alu_a = VECS[i].a; alu_b = VECS[i].b;
            @(negedge clk);
            alu_valid = 1'b0;
            chk($sformatf("R2/R3/R4/R5 flags v%0d", i), {28'd0, cc_flags}, {28'd0, VECS[i].xflags});
            br_valid = 1'b1; br_opcode = VECS[i].opc; br_disp = VECS[i].disp; br_next_pc = VECS[i].npc;
            @(negedge clk);
            br_valid = 1'b0;
            chk($sformatf("R6 valid v%0d", i), {31'd0, res_valid}, 32'd1);
            chk($sformatf("R8-R13 taken v%0d", i), {31'd0, res_taken}, {31'd0, VECS[i].xtaken});
            chk($sformatf("R13 illegal v%0d", i), {31'd0, res_illegal}, {31'd0, VECS[i].xillegal});
            chk($sformatf("R7/R14 npc v%0d", i), res_npc, VECS[i].xnpc);
            chk($sformatf("R2 flags kept after branch v%0d", i), {28'd0, cc_flags}, {28'd0, VECS[i].xflags});
        end

        // R6: res_valid drops after a cycle without a request.
        @(negedge clk);
        chk("R6 idle valid", {31'd0, res_valid}, 32'd0);

        // R6: same-cycle update is not seen. Flags are 1010 (Z=0); SUB 5-5 sets Z.
        alu_valid = 1'b1; alu_op = 2'd1; alu_a = 32'h5; alu_b = 32'h5;
        br_valid = 1'b1; br_opcode = 8'h13; br_disp = 16'h0010; br_next_pc = 32'hB000;
        @(negedge clk);
        alu_valid = 1'b0; br_valid = 1'b0;
        chk("R6 old flags used taken", {31'd0, res_taken}, 32'd0);
        chk("R6 old flags used npc", res_npc, 32'hB000);
        chk("R2 new flags loaded", {28'd0, cc_flags}, 32'b0100);

        // R2: several branches in a row leave the flags alone.
        for (int k = 0; k < 3; k++) begin
            br_valid = 1'b1; br_opcode = 8'h11; br_disp = 16'h0001; br_next_pc = 32'hC000;
            @(negedge clk);
        end
        br_valid = 1'b0;
        chk("R2 flags after branch burst", {28'd0, cc_flags}, 32'b0100);
        chk("R8 short taken npc", res_npc, 32'hC001);

        // R1: reset mid-run clears everything.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset flags", {28'd0, cc_flags}, 32'd0);
        chk("R1 reset valid", {31'd0, res_valid}, 32'd0);
        chk("R1 reset npc", res_npc, 32'd0);

        @(negedge clk);
        finish_run();
    end

endmodule